// File: doc/BRIEF.md
# Speculative Update Message Generator

This block sits on the writer side of a cache and watches the local core's stores. A store that takes ownership of a line produces an invalidation descriptor for the bus request queue. Depending on the selected mode, that invalidation can also carry a hint about the new value, so that remote caches holding stale copies can refresh them while they wait for the coherent line. A hint is either the full stored word or a 2-bit code that stands for one of three common small values.

The block also keeps a write count for every owned line, indexed by the line-index bits of the address and with no tag. When the same writer reaches a fixed number of writes to a line after acquiring it, the block emits one word-update descriptor. The descriptor carries only the written word and its word address. Updates are hints only. They never stall a store, and they are discarded rather than held when the queue reports no room for speculative traffic. The queue always accepts invalidations.

Top module: `spec_upd_gen`

## Requirements
- R1: While `rst` is high, and after it is released, `msg_valid` is 0. No line counts as owned after reset, so a non-invalidating store made before any acquisition emits nothing.
- R2: Every store with `st_inv`=1 produces exactly one descriptor, two clock edges after the store is presented. That descriptor has `msg_kind`=0 (invalidate), `msg_addr` equal to `st_addr`, and is emitted whatever the value of `q_full`. A cycle with no store produces no descriptor two edges later.
- R3: With `inv_mode`=01 (full value), an invalidation has `msg_data_vld`=1, `msg_data` equal to the stored word, and `msg_code`=00.
- R4: With `inv_mode`=10 (compressed), an invalidation has `msg_data_vld`=0 and `msg_data`=0. Its `msg_code` is 01 for a stored 0, 10 for a stored 1, 11 for all ones (-1), and 00 for any other value.
- R5: With `inv_mode`=00 or 11 (plain), an invalidation has `msg_code`=00, `msg_data_vld`=0 and `msg_data`=0.
- R6: The acquiring store counts as write 1. On write `WRITE_LIMIT` (default 5) to an owned line, if `cnt_en`=1 and `q_full`=0, the block emits one update descriptor: `msg_kind`=1, the address and data of that store, `msg_data_vld`=1, `msg_code`=00.
- R7: In one ownership period, stores after write `WRITE_LIMIT` emit nothing. A new acquiring store restarts the count at 1.
- R8: If `q_full`=1 with the store that reaches the limit, the update is dropped and is not retried by later stores.
- R9: If `cnt_en`=0 with the store that reaches the limit, no update is sent, but the write still counts, so later stores do not fire.
- R10: A non-invalidating store to a line index never acquired since reset emits nothing and does not start a count.
- R11: Lines with different index bits (`st_addr[OFF_W +: IDX_W]`) are counted separately. Back-to-back stores to the same line on consecutive cycles are each counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store retires this cycle |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Stored word |
| st_inv | input | 1 | Store acquires the line and needs an invalidation |
| inv_mode | input | 2 | Hint carried on invalidations: 00 plain, 01 full, 10 compressed, 11 plain |
| cnt_en | input | 1 | Allows write-count updates |
| q_full | input | 1 | Queue has no room for speculative updates |
| msg_valid | output | 1 | Descriptor valid |
| msg_kind | output | 1 | 0 invalidate, 1 word update |
| msg_addr | output | ADDR_W | Word address |
| msg_data | output | DATA_W | Word value when `msg_data_vld` |
| msg_data_vld | output | 1 | Descriptor carries a full word |
| msg_code | output | 2 | Compressed value code |

## Verification
The hardest case to reach is a line reaching its write limit while a store to the same index is still in flight in the pipeline. This requires consecutive same-line stores, so that the count is forwarded instead of being read from the table. Directed sequences drive five back-to-back stores to one line. They also interleave limit crossings with `q_full` and `cnt_en` changes, and re-acquire a line. The random phase then confines the index to four values, so that aliasing, re-acquisition and consecutive same-line writes happen often against the bench's own count model.

// File: rtl/sug_pkg.sv
package sug_pkg;
  typedef enum logic [1:0] {
    HINT_PLAIN = 2'b00,
    HINT_FULL  = 2'b01,
    HINT_COMP  = 2'b10,
    HINT_RSVD  = 2'b11
  } hint_mode_e;

  localparam logic [1:0] VCODE_NONE  = 2'b00;
  localparam logic [1:0] VCODE_ZERO  = 2'b01;
  localparam logic [1:0] VCODE_ONE   = 2'b10;
  localparam logic [1:0] VCODE_MINUS = 2'b11;

  localparam logic KIND_INV = 1'b0;
  localparam logic KIND_UPD = 1'b1;
endpackage

// File: rtl/sug_value_code.sv
module sug_value_code #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  output logic [1:0]        code
);
  import sug_pkg::*;
  always_comb begin
    if (value == '0)                  code = VCODE_ZERO;
    else if (value == DATA_W'(1))     code = VCODE_ONE;
    else if (value == {DATA_W{1'b1}}) code = VCODE_MINUS;
    else                              code = VCODE_NONE;
  end
endmodule

// File: rtl/sug_write_tracker.sv
module sug_write_tracker #(
  parameter int LINES = 64,
  parameter int CNT_W = 3,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_own,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             cur_owned
);
  // count storage: no reset, registered read, so it maps to block RAM
  logic [CNT_W-1:0] cnt_mem [LINES];
  logic [CNT_W-1:0] rd_q;
  // ownership flags in flops so reset clears them in one cycle
  logic [LINES-1:0] own_q;
  // one-deep forwarding of the write just made
  logic             fw_vld;
  logic [IDX_W-1:0] fw_idx;
  logic [CNT_W-1:0] fw_cnt;

  always_ff @(posedge clk) begin
    if (wr_en) cnt_mem[cur_idx] <= wr_cnt;
    rd_q <= cnt_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= '0;
      fw_vld <= 1'b0;
      fw_idx <= '0;
      fw_cnt <= '0;
    end else begin
      if (wr_en && wr_own) own_q[cur_idx] <= 1'b1;
      fw_vld <= wr_en;
      fw_idx <= cur_idx;
      fw_cnt <= wr_cnt;
    end
  end

  assign cur_cnt   = (fw_vld && fw_idx == cur_idx) ? fw_cnt : rd_q;
  assign cur_owned = own_q[cur_idx];
endmodule

// File: rtl/sug_msg_reg.sv
module sug_msg_reg #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic              d_kind,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_data_vld,
  input  logic [1:0]        d_code,
  output logic              q_valid,
  output logic              q_kind,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data,
  output logic              q_data_vld,
  output logic [1:0]        q_code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid    <= 1'b0;
      q_kind     <= 1'b0;
      q_addr     <= '0;
      q_data     <= '0;
      q_data_vld <= 1'b0;
      q_code     <= '0;
    end else begin
      q_valid    <= d_valid;
      q_kind     <= d_kind;
      q_addr     <= d_addr;
      q_data     <= d_data;
      q_data_vld <= d_data_vld;
      q_code     <= d_code;
    end
  end
endmodule

// File: rtl/spec_upd_gen.sv
module spec_upd_gen #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 16,
  parameter int LINES       = 64,
  parameter int WRITE_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_inv,
  input  logic [1:0]        inv_mode,
  input  logic              cnt_en,
  input  logic              q_full,
  output logic              msg_valid,
  output logic              msg_kind,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data,
  output logic              msg_data_vld,
  output logic [1:0]        msg_code
);
  import sug_pkg::*;

  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int CNT_W = $clog2(WRITE_LIMIT + 1);

  initial begin
    if (WRITE_LIMIT < 2) $error("WRITE_LIMIT must be at least 2");
  end

  // stage 1: captured store
  logic              s1_vld, s1_inv, s1_cnt_en, s1_full;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;
  hint_mode_e        s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld    <= 1'b0;
      s1_inv    <= 1'b0;
      s1_cnt_en <= 1'b0;
      s1_full   <= 1'b0;
      s1_addr   <= '0;
      s1_data   <= '0;
      s1_mode   <= HINT_PLAIN;
    end else begin
      s1_vld    <= st_valid;
      s1_inv    <= st_inv;
      s1_cnt_en <= cnt_en;
      s1_full   <= q_full;
      s1_addr   <= st_addr;
      s1_data   <= st_data;
      s1_mode   <= hint_mode_e'(inv_mode);
    end
  end

  logic [IDX_W-1:0] rd_idx, s1_idx;
  logic [CNT_W-1:0] cur_cnt, next_cnt;
  logic             cur_owned, inc_ok, wr_en, fire;
  logic [1:0]       val_code;

  assign rd_idx = st_addr[OFF_W +: IDX_W];
  assign s1_idx = s1_addr[OFF_W +: IDX_W];

  sug_write_tracker #(.LINES(LINES), .CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (rd_idx),
    .cur_idx   (s1_idx),
    .wr_en     (wr_en),
    .wr_cnt    (next_cnt),
    .wr_own    (s1_inv),
    .cur_cnt   (cur_cnt),
    .cur_owned (cur_owned)
  );

  sug_value_code #(.DATA_W(DATA_W)) u_code (
    .value (s1_data),
    .code  (val_code)
  );

  assign inc_ok   = s1_vld && !s1_inv && cur_owned && (cur_cnt < CNT_W'(WRITE_LIMIT));
  assign next_cnt = s1_inv ? CNT_W'(1) : cur_cnt + CNT_W'(1);
  assign wr_en    = (s1_vld && s1_inv) || inc_ok;
  assign fire     = inc_ok && (next_cnt == CNT_W'(WRITE_LIMIT)) && s1_cnt_en && !s1_full;

  logic              m_valid, m_kind, m_dv;
  logic [DATA_W-1:0] m_data;
  logic [1:0]        m_code;

  always_comb begin
    m_valid = (s1_vld && s1_inv) || fire;
    m_kind  = s1_inv ? KIND_INV : KIND_UPD;
    m_code  = VCODE_NONE;
    m_dv    = 1'b1;
    if (s1_inv) begin
      m_dv = (s1_mode == HINT_FULL);
      if (s1_mode == HINT_COMP) m_code = val_code;
    end
    m_data = m_dv ? s1_data : '0;
  end

  sug_msg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .d_valid    (m_valid),
    .d_kind     (m_kind),
    .d_addr     (s1_addr),
    .d_data     (m_data),
    .d_data_vld (m_dv),
    .d_code     (m_code),
    .q_valid    (msg_valid),
    .q_kind     (msg_kind),
    .q_addr     (msg_addr),
    .q_data     (msg_data),
    .q_data_vld (msg_data_vld),
    .q_code     (msg_code)
  );
endmodule

// File: rtl/sug_checker.sv
module sug_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              st_valid,
  input logic              st_inv,
  input logic [1:0]        inv_mode,
  input logic              cnt_en,
  input logic              q_full,
  input logic              msg_valid,
  input logic              msg_kind,
  input logic              msg_data_vld,
  input logic [1:0]        msg_code
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !msg_valid);

  p_inv_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && $past(st_valid && st_inv, 2)) |-> (msg_valid && !msg_kind));

  p_no_store_no_msg_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && !$past(st_valid, 2)) |-> !msg_valid);

  p_code_on_comp_inv_r4: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_code != 2'b00) |-> (!msg_kind && !msg_data_vld && $past(inv_mode, 2) == 2'b10));

  p_update_shape_r6: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind) |-> (msg_data_vld && msg_code == 2'b00));

  p_drop_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && $past(st_valid && !st_inv && q_full, 2)) |-> !msg_valid);

  p_update_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && msg_valid && msg_kind) |-> $past(cnt_en, 2));
endmodule

bind spec_upd_gen sug_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .st_valid     (st_valid),
  .st_inv       (st_inv),
  .inv_mode     (inv_mode),
  .cnt_en       (cnt_en),
  .q_full       (q_full),
  .msg_valid    (msg_valid),
  .msg_kind     (msg_kind),
  .msg_data_vld (msg_data_vld),
  .msg_code     (msg_code)
);

// File: tb/tb_spec_upd_gen.sv
module tb_spec_upd_gen;
  localparam int LIMIT = 5;
  localparam int LINES = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0, st_inv = 1'b0, cnt_en = 1'b0, q_full = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [1:0]  inv_mode = 2'b00;
  logic        msg_valid, msg_kind, msg_data_vld;
  logic [31:0] msg_addr, msg_data;
  logic [1:0]  msg_code;

  always #10 clk = ~clk;

  spec_upd_gen dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_inv(st_inv), .inv_mode(inv_mode), .cnt_en(cnt_en), .q_full(q_full),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_addr(msg_addr), .msg_data(msg_data),
    .msg_data_vld(msg_data_vld), .msg_code(msg_code)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    bit          v;
    bit          k;
    logic [31:0] a;
    logic [31:0] d;
    bit          dv;
    logic [1:0]  c;
    int          tag;
  } exp_t;

  exp_t pipe0, pipe1;
  int   m_cnt [LINES];
  bit   m_own [LINES];

  function automatic logic [1:0] vcode(logic [31:0] x);
    if (x == 32'd0) return 2'b01;
    if (x == 32'd1) return 2'b10;
    if (x == 32'hFFFF_FFFF) return 2'b11;
    return 2'b00;
  endfunction

  // expected descriptor from the requirements, updating the count model
  function automatic exp_t model(bit v, logic [31:0] a, logic [31:0] d, bit inv,
                                 logic [1:0] mode, bit en, bit full);
    exp_t e;
    int   ix;
    e = '{v:0, k:0, a:'0, d:'0, dv:0, c:2'b00, tag:2};
    ix = int'(a[9:4]);
    if (!v) return e;
    if (inv) begin
      m_own[ix] = 1; m_cnt[ix] = 1;
      e.v = 1; e.k = 0; e.a = a;
      if (mode == 2'b01) begin e.dv = 1; e.d = d; e.tag = 3; end      // R3
      else if (mode == 2'b10) begin e.c = vcode(d); e.tag = 4; end   // R4
      else e.tag = 5;                                                // R5
    end else if (m_own[ix] && m_cnt[ix] < LIMIT) begin
      m_cnt[ix]++;
      e.tag = 11;                                                    // R11
      if (m_cnt[ix] == LIMIT) begin
        if (full) e.tag = 8;                                         // R8
        else if (!en) e.tag = 9;                                     // R9
        else begin e.v = 1; e.k = 1; e.a = a; e.d = d; e.dv = 1; e.tag = 6; end // R6
      end
    end else begin
      e.tag = m_own[ix] ? 7 : 10;                                    // R7 / R10
    end
    return e;
  endfunction

  task automatic chk(string what, int tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] a, logic [31:0] d, bit inv,
                      logic [1:0] mode, bit en, bit full);
    @(negedge clk);
    cycles++;
    chk("msg_valid", pipe1.tag, 32'(msg_valid), 32'(pipe1.v));
    if (pipe1.v) begin
      chk("msg_kind", pipe1.tag, 32'(msg_kind), 32'(pipe1.k));
      chk("msg_addr", pipe1.tag, msg_addr, pipe1.a);
      chk("msg_data", pipe1.tag, msg_data, pipe1.d);
      chk("msg_data_vld", pipe1.tag, 32'(msg_data_vld), 32'(pipe1.dv));
      chk("msg_code", pipe1.tag, 32'(msg_code), 32'(pipe1.c));
    end
    pipe1 = pipe0;
    pipe0 = model(v, a, d, inv, mode, en, full);
    st_valid = v; st_addr = a; st_data = d; st_inv = inv;
    inv_mode = mode; cnt_en = en; q_full = full;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, 2'b00, 1, 0);
  endtask

  function automatic logic [31:0] line_addr(int ix, int off, int hi);
    return {22'(hi), 6'(ix), 4'(off)};
  endfunction

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    pipe0 = '{v:0, k:0, a:'0, d:'0, dv:0, c:2'b00, tag:1};
    pipe1 = pipe0;
    for (int i = 0; i < LINES; i++) begin m_cnt[i] = 0; m_own[i] = 0; end
    repeat (3) @(negedge clk);
    chk("msg_valid in reset", 1, 32'(msg_valid), 32'd0);             // R1
    rst = 1'b0;
    pipe0.tag = 1; pipe1.tag = 1;
    // R1/R10: unowned line store after reset emits nothing
    step(0, '0, '0, 0, 2'b00, 1, 0);
    step(1, line_addr(3, 2, 7), 32'h55, 0, 2'b00, 1, 0);
    idle(2);

    // R3, R4, R5: hint modes on invalidations (with q_full set: R2)
    step(1, line_addr(1, 0, 1), 32'hDEAD_BEEF, 1, 2'b01, 1, 1);
    step(1, line_addr(2, 1, 1), 32'd0, 1, 2'b10, 1, 0);
    step(1, line_addr(2, 2, 1), 32'd1, 1, 2'b10, 1, 1);
    step(1, line_addr(2, 3, 1), 32'hFFFF_FFFF, 1, 2'b10, 1, 0);
    step(1, line_addr(2, 4, 1), 32'd2, 1, 2'b10, 1, 0);
    step(1, line_addr(4, 5, 1), 32'd0, 1, 2'b00, 1, 0);
    step(1, line_addr(5, 6, 1), 32'hAB, 1, 2'b11, 1, 0);
    idle(2);

    // R6/R11: acquire + 4 back-to-back writes -> update on 5th; R7 after
    step(1, line_addr(9, 0, 2), 32'h10, 1, 2'b00, 1, 0);
    for (int i = 1; i < 5; i++) step(1, line_addr(9, i, 2), 32'h10 + 32'(i), 0, 2'b00, 1, 0);
    step(1, line_addr(9, 7, 2), 32'h77, 0, 2'b00, 1, 0);
    step(1, line_addr(9, 8, 2), 32'h78, 0, 2'b00, 1, 0);
    // R7: reacquire restarts count, interleaved with another line (R11)
    step(1, line_addr(9, 0, 2), 32'h20, 1, 2'b01, 1, 0);
    step(1, line_addr(10, 0, 2), 32'h30, 1, 2'b10, 1, 0);
    for (int i = 1; i < 5; i++) begin
      step(1, line_addr(9, i, 2), 32'h20 + 32'(i), 0, 2'b00, 1, 0);
      step(1, line_addr(10, i, 2), 32'h30 + 32'(i), 0, 2'b00, 1, 0);
    end
    idle(2);

    // R8: queue full at limit -> dropped, not retried
    step(1, line_addr(12, 0, 3), 32'h1, 1, 2'b00, 1, 0);
    for (int i = 1; i < 4; i++) step(1, line_addr(12, i, 3), 32'h2, 0, 2'b00, 1, 0);
    step(1, line_addr(12, 4, 3), 32'h3, 0, 2'b00, 1, 1);
    step(1, line_addr(12, 5, 3), 32'h4, 0, 2'b00, 1, 0);
    // R9: counting disabled at limit -> no update, still counted
    step(1, line_addr(13, 0, 3), 32'h1, 1, 2'b00, 1, 0);
    for (int i = 1; i < 4; i++) step(1, line_addr(13, i, 3), 32'h2, 0, 2'b00, 1, 0);
    step(1, line_addr(13, 4, 3), 32'h3, 0, 2'b00, 0, 0);
    step(1, line_addr(13, 5, 3), 32'h4, 0, 2'b00, 1, 0);
    idle(2);

    // random phase over four aliased indices
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, d;
      int          sel;
      a = $urandom;
      sel = int'($urandom % 4);
      a[9:4] = 6'(sel * 5 + 20);
      case ($urandom % 4)
        0: d = 32'd0;
        1: d = 32'd1;
        2: d = 32'hFFFF_FFFF;
        default: d = $urandom;
      endcase
      step(($urandom % 10) < 8, a, d, ($urandom % 8) == 0, 2'($urandom),
           ($urandom % 10) != 0, ($urandom % 6) == 0);
    end
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule